// File: doc/BRIEF.md
# Four-State Strap Address Resolver

This block works out the 7-bit target address of a bus device from three strap pins. Each pin can be wired in one of four ways: to ground, to the supply, to the serial data line or to the serial clock line. The resolver samples the three pins together with the live data and clock lines of a two-wire serial bus. It decides how each pin is wired by watching whether the pin tracks one of the bus lines, or stays fixed while both lines move. It then looks the three-pin combination up in an irregular address table.

Once all three pins are resolved, the block drives the address and a valid flag. It also watches the bus for a START condition. It shifts in the first byte that follows the START, and raises a one-cycle match pulse when the upper seven bits of that byte equal the resolved address. A combination that has no table entry raises an error flag, and that combination never produces a match.

Top module: `strap_addr_decoder`

## Requirements
- R1: A pin is resolved as tracking the data line (code 2) once it has equalled the new data-line level on at least MIN_EDGES data-line transitions and has never differed from the new level on any data-line transition.
- R2: A pin that fails R1 is resolved as tracking the clock line (code 3) under the same rule, applied to clock-line transitions.
- R3: A pin that fails R1 and R2 is resolved as static (low = code 0, high = code 1) only if it has never changed and both bus lines have each made at least MIN_EDGES transitions. Transitions are counted from the third clock after reset.
- R4: `valid_o` is low until all three pins are resolved. While it is low, `addr_o` is 0.
- R5: The address table is indexed by the triple (A2,A1,A0) = (`strap_i[2]`,`strap_i[1]`,`strap_i[0]`). Entry n gives `addr_o` = 20h + n, which is address byte 40h + 2n. These entries are checked: (low,low,data)=20h, (high,high,data)=23h, (low,data,high)=25h, (data,data,low)=30h, (data,data,high)=31h, (data,data,data)=32h, (clock,clock,clock)=33h, (low,clock,clock)=40h, (clock,clock,high)=45h.
- R6: A resolved combination with no table entry, for example all three pins low, drives `err_o` high and `addr_o` to 0. Such a combination never raises `match_o`, not even for address byte 00h.
- R7: `match_o` is high for exactly one clock. It rises one clock after the resolver registers the 8th clock-line rising edge that follows a START, and only when bits 7:1 of that byte equal `addr_o` and the pins are resolved. A START is the data line falling while the clock line is high.
- R8: While `valid_o` is low, no match is raised, even when the byte on the bus carries the address.
- R9: Only the first byte after a START is compared. A later byte in the same transfer that carries the address, or a first byte with a different address, gives no pulse.
- R10: Under reset, `valid_o`, `err_o` and `match_o` are low and `addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | Bus data line level |
| scl_i | input | 1 | Bus clock line level |
| strap_i | input | 3 | Strap pins, bit 2 = A2, bit 0 = A0 |
| addr_o | output | 7 | Resolved 7-bit address, 0 when not resolved or undefined |
| valid_o | output | 1 | All three pins resolved |
| err_o | output | 1 | Resolved combination has no table entry |
| match_o | output | 1 | One-cycle pulse on an address hit |

## Verification
The bench builds the resolver with MIN_EDGES = 6. With this value, a first address byte such as 40h ends before a statically tied pin has seen enough data-line transitions. That makes the suppression of a match before resolution observable on an ordinary transfer. Three further transfers then resolve every pin, including the all-bus wirings and one undefined combination. A behavioural model tracks the resolution and the byte capture on every clock.

// File: rtl/strap_addr_decoder.sv
`timescale 1ns/1ps
module strap_addr_decoder #(
  parameter int MIN_EDGES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_i,
  input  logic       scl_i,
  input  logic [2:0] strap_i,
  output logic [6:0] addr_o,
  output logic       valid_o,
  output logic       err_o,
  output logic       match_o
);
  localparam int CW = $clog2(MIN_EDGES + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_EDGES);
  localparam logic [1:0] ST_LO = 2'd0, ST_HI = 2'd1, ST_SDA = 2'd2, ST_SCL = 2'd3;

  function automatic logic [6:0] lut(input logic [5:0] k);
    case (k)
      {ST_LO,  ST_LO,  ST_SDA}: lut = {1'b1, 6'd0};
      {ST_LO,  ST_HI,  ST_SDA}: lut = {1'b1, 6'd1};
      {ST_HI,  ST_LO,  ST_SDA}: lut = {1'b1, 6'd2};
      {ST_HI,  ST_HI,  ST_SDA}: lut = {1'b1, 6'd3};
      {ST_LO,  ST_SDA, ST_LO }: lut = {1'b1, 6'd4};
      {ST_LO,  ST_SDA, ST_HI }: lut = {1'b1, 6'd5};
      {ST_HI,  ST_SDA, ST_LO }: lut = {1'b1, 6'd6};
      {ST_HI,  ST_SDA, ST_HI }: lut = {1'b1, 6'd7};
      {ST_SDA, ST_LO,  ST_LO }: lut = {1'b1, 6'd8};
      {ST_SDA, ST_LO,  ST_HI }: lut = {1'b1, 6'd9};
      {ST_SDA, ST_HI,  ST_LO }: lut = {1'b1, 6'd10};
      {ST_SDA, ST_HI,  ST_HI }: lut = {1'b1, 6'd11};
      {ST_LO,  ST_SDA, ST_SDA}: lut = {1'b1, 6'd12};
      {ST_HI,  ST_SDA, ST_SDA}: lut = {1'b1, 6'd13};
      {ST_SDA, ST_LO,  ST_SDA}: lut = {1'b1, 6'd14};
      {ST_SDA, ST_HI,  ST_SDA}: lut = {1'b1, 6'd15};
      {ST_SDA, ST_SDA, ST_LO }: lut = {1'b1, 6'd16};
      {ST_SDA, ST_SDA, ST_HI }: lut = {1'b1, 6'd17};
      {ST_SDA, ST_SDA, ST_SDA}: lut = {1'b1, 6'd18};
      {ST_SCL, ST_SCL, ST_SCL}: lut = {1'b1, 6'd19};
      {ST_LO,  ST_LO,  ST_SCL}: lut = {1'b1, 6'd20};
      {ST_LO,  ST_HI,  ST_SCL}: lut = {1'b1, 6'd21};
      {ST_HI,  ST_LO,  ST_SCL}: lut = {1'b1, 6'd22};
      {ST_HI,  ST_HI,  ST_SCL}: lut = {1'b1, 6'd23};
      {ST_LO,  ST_SCL, ST_LO }: lut = {1'b1, 6'd24};
      {ST_LO,  ST_SCL, ST_HI }: lut = {1'b1, 6'd25};
      {ST_HI,  ST_SCL, ST_LO }: lut = {1'b1, 6'd26};
      {ST_HI,  ST_SCL, ST_HI }: lut = {1'b1, 6'd27};
      {ST_SCL, ST_LO,  ST_LO }: lut = {1'b1, 6'd28};
      {ST_SCL, ST_LO,  ST_HI }: lut = {1'b1, 6'd29};
      {ST_SCL, ST_HI,  ST_LO }: lut = {1'b1, 6'd30};
      {ST_SCL, ST_HI,  ST_HI }: lut = {1'b1, 6'd31};
      {ST_LO,  ST_SCL, ST_SCL}: lut = {1'b1, 6'd32};
      {ST_HI,  ST_SCL, ST_SCL}: lut = {1'b1, 6'd33};
      {ST_SCL, ST_LO,  ST_SCL}: lut = {1'b1, 6'd34};
      {ST_SCL, ST_HI,  ST_SCL}: lut = {1'b1, 6'd35};
      {ST_SCL, ST_SCL, ST_LO }: lut = {1'b1, 6'd36};
      {ST_SCL, ST_SCL, ST_HI }: lut = {1'b1, 6'd37};
      default:                  lut = 7'd0;
    endcase
  endfunction

  logic       s_q, s_p, c_q, c_p;
  logic [2:0] p_q, p_p;
  logic [1:0] warm;
  logic [CW-1:0] ts, tc;
  logic [5:0] key;
  logic [2:0] known;

  wire live  = (warm == 2'd2);
  wire sda_e = s_q ^ s_p;
  wire scl_e = c_q ^ c_p;
  wire start = c_q & c_p & s_p & ~s_q;
  wire scl_r = c_q & ~c_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= 1'b1; s_p <= 1'b1; c_q <= 1'b1; c_p <= 1'b1;
      p_q <= '0;   p_p <= '0;   warm <= '0;
      ts  <= '0;   tc  <= '0;
    end else begin
      s_q <= sda_i; s_p <= s_q; c_q <= scl_i; c_p <= c_q;
      p_q <= strap_i; p_p <= p_q;
      if (!live) warm <= warm + 2'd1;
      if (live && sda_e && ts != LIM) ts <= ts + 1'b1;
      if (live && scl_e && tc != LIM) tc <= tc + 1'b1;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_pin
    logic [CW-1:0] dh, ch;
    logic db, cb, mv;
    logic [1:0] st;
    logic kn;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dh <= '0; ch <= '0; db <= 1'b0; cb <= 1'b0; mv <= 1'b0;
      end else if (live) begin
        if (sda_e) begin
          if (p_q[i] == s_q) begin
            if (dh != LIM) dh <= dh + 1'b1;
          end else db <= 1'b1;
        end
        if (scl_e) begin
          if (p_q[i] == c_q) begin
            if (ch != LIM) ch <= ch + 1'b1;
          end else cb <= 1'b1;
        end
        if (p_q[i] ^ p_p[i]) mv <= 1'b1;
      end
    end

    always_comb begin
      kn = 1'b1;
      st = ST_LO;
      if (!db && dh == LIM)                      st = ST_SDA;
      else if (!cb && ch == LIM)                 st = ST_SCL;
      else if (!mv && ts == LIM && tc == LIM)    st = p_q[i] ? ST_HI : ST_LO;
      else                                       kn = 1'b0;
    end

    assign key[2*i +: 2] = st;
    assign known[i] = kn;
  end

  logic [6:0] hit_idx;
  assign hit_idx = lut(key);
  assign valid_o = &known;
  assign err_o   = valid_o & ~hit_idx[6];
  assign addr_o  = (valid_o & hit_idx[6]) ? 7'h20 + {1'b0, hit_idx[5:0]} : 7'd0;

  logic       armed;
  logic [2:0] nb;
  logic [6:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; nb <= '0; sh <= '0; match_o <= 1'b0;
    end else begin
      match_o <= 1'b0;
      if (live && start) begin
        armed <= 1'b1;
        nb    <= '0;
      end else if (live && armed && scl_r) begin
        sh <= {sh[5:0], s_q};
        nb <= nb + 3'd1;
        if (nb == 3'd7) begin
          armed   <= 1'b0;
          match_o <= valid_o & ~err_o & (sh == addr_o);
        end
      end
    end
  end

  // R7
  match_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o);
  // R7
  match_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(c_q && !c_p));
  // R8
  match_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(valid_o));
  // R4
  addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (addr_o == 7'd0 && !err_o));
  // R6
  err_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_o) |-> !match_o);
endmodule

// File: tb/sim_strap_addr_decoder.sv
`timescale 1ns/1ps
module sim_strap_addr_decoder;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sda_b = 1'b1, scl_b = 1'b1;
  int   sel [3] = '{0, 0, 0};
  logic [2:0] strap;
  logic [6:0] addr_o;
  logic valid_o, err_o, match_o;

  int checks = 0, fails = 0, pulses = 0;
  bit running = 1'b0;
  bit [6:0] exp_addr = '0;
  bit exp_err = 1'b0;

  always #10 clk = ~clk;

  for (genvar i = 0; i < 3; i++) begin : g_s
    assign strap[i] = (sel[i] == 0) ? 1'b0 : (sel[i] == 1) ? 1'b1 :
                      (sel[i] == 2) ? sda_b : scl_b;
  end

  strap_addr_decoder #(.MIN_EDGES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_b), .scl_i(scl_b), .strap_i(strap),
    .addr_o(addr_o), .valid_o(valid_o), .err_o(err_o), .match_o(match_o));

  // behavioural reference
  int hs[3], hc[3], ts, tc, warm, nb;
  bit bs[3], bc[3], mv[3], p1[3], p2[3];
  bit s1, s2, c1, c2, armed, m_match;
  bit [6:0] sh;

  function automatic int cls(int i);
    if (!bs[i] && hs[i] >= N) return 2;
    if (!bc[i] && hc[i] >= N) return 3;
    if (!mv[i] && ts >= N && tc >= N) return p1[i] ? 1 : 0;
    return -1;
  endfunction

  function automatic bit mval();
    return cls(0) >= 0 && cls(1) >= 0 && cls(2) >= 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        hs[i] = 0; hc[i] = 0; bs[i] = 0; bc[i] = 0; mv[i] = 0; p1[i] = 0; p2[i] = 0;
      end
      ts = 0; tc = 0; warm = 0; nb = 0; armed = 0; m_match = 0; sh = '0;
      s1 = 1; s2 = 1; c1 = 1; c2 = 1;
    end else begin
      bit live, v;
      live = (warm == 2);
      v = mval();
      m_match = 0;
      if (live && c1 && c2 && s2 && !s1) begin
        armed = 1; nb = 0;
      end else if (live && armed && c1 && !c2) begin
        if (nb == 7) begin
          armed = 0;
          m_match = v && !exp_err && (sh == exp_addr);
        end
        sh = {sh[5:0], s1};
        nb++;
      end
      if (live) begin
        for (int i = 0; i < 3; i++) begin
          if (s1 != s2) begin
            if (p1[i] == s1) hs[i] = (hs[i] < N) ? hs[i] + 1 : N; else bs[i] = 1;
          end
          if (c1 != c2) begin
            if (p1[i] == c1) hc[i] = (hc[i] < N) ? hc[i] + 1 : N; else bc[i] = 1;
          end
          if (p1[i] != p2[i]) mv[i] = 1;
        end
        if (s1 != s2 && ts < N) ts++;
        if (c1 != c2 && tc < N) tc++;
      end
      if (warm < 2) warm++;
      s2 = s1; s1 = sda_b; c2 = c1; c1 = scl_b;
      for (int i = 0; i < 3; i++) begin
        p2[i] = p1[i]; p1[i] = strap[i];
      end
    end
  end

  always @(negedge clk) begin
    if (match_o) pulses++;
    if (rst_n && running) begin
      bit v;
      v = mval();
      checks++;
      if (valid_o !== v || match_o !== m_match ||
          addr_o !== (v && !exp_err ? exp_addr : 7'd0) || err_o !== (v && exp_err)) begin
        fails++;
        $display("FAIL R4 R5 R6 R7 per-clock: valid=%0b/%0b match=%0b/%0b addr=%h/%h err=%0b/%0b",
                 valid_o, v, match_o, m_match, addr_o, (v && !exp_err) ? exp_addr : 7'd0,
                 err_o, v && exp_err);
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic hold(); repeat (2) @(negedge clk); endtask
  task automatic put_bit(input bit b);
    sda_b = b; hold(); scl_b = 1; hold(); scl_b = 0; hold();
  endtask
  task automatic start_c(); sda_b = 1; scl_b = 1; hold(); sda_b = 0; hold(); scl_b = 0; hold(); endtask
  task automatic stop_c(); sda_b = 0; hold(); scl_b = 1; hold(); sda_b = 1; hold(); endtask
  task automatic put_byte(input bit [7:0] b);
    for (int k = 7; k >= 0; k--) put_bit(b[k]);
    put_bit(1'b1);
  endtask

  task automatic run_case(input int a2, input int a1, input int a0,
                          input bit [6:0] ea, input bit ee, input bit pre_chk, input string tag);
    running = 0;
    rst_n = 0; sda_b = 1; scl_b = 1;
    sel[2] = a2; sel[1] = a1; sel[0] = a0;
    exp_addr = ea; exp_err = ee;
    repeat (3) @(negedge clk);
    // R10
    chk(valid_o === 0 && match_o === 0 && addr_o === 0 && err_o === 0,
        {"R10 reset state ", tag}, {valid_o, match_o, err_o, addr_o}, 0);
    rst_n = 1; running = 1;
    pulses = 0;
    start_c(); put_byte({ea, 1'b0}); stop_c();
    // R8
    if (pre_chk) chk(pulses == 0, {"R8 no match before valid ", tag}, pulses, 0);
    start_c(); put_byte(8'hA5); stop_c();
    start_c(); put_byte(8'hA5); stop_c();
    // R1 R2 R3 R4
    chk(valid_o === 1, {"R1 R2 R3 R4 resolved ", tag}, valid_o, 1);
    // R5 R6
    chk(addr_o === (ee ? 7'd0 : ea) && err_o === ee, {"R5 R6 address ", tag},
        {err_o, addr_o}, {ee, ee ? 7'd0 : ea});
    pulses = 0;
    start_c(); put_byte({ea, 1'b0}); put_byte({ea, 1'b0}); stop_c();
    // R7 R9 R6
    chk(pulses == (ee ? 0 : 1), {"R7 R9 R6 pulse count ", tag}, pulses, ee ? 0 : 1);
    pulses = 0;
    start_c(); put_byte({ea ^ 7'h01, 1'b0}); stop_c();
    // R9
    chk(pulses == 0, {"R9 other address ", tag}, pulses, 0);
  endtask

  bit done = 0;
  initial begin
    run_case(0, 0, 2, 7'h20, 0, 1, "LLD");
    run_case(1, 1, 2, 7'h23, 0, 0, "HHD");
    run_case(0, 2, 1, 7'h25, 0, 0, "LDH");
    run_case(2, 2, 0, 7'h30, 0, 0, "DDL");
    run_case(2, 2, 1, 7'h31, 0, 0, "DDH");
    run_case(2, 2, 2, 7'h32, 0, 0, "DDD");
    run_case(3, 3, 3, 7'h33, 0, 0, "CCC");
    run_case(0, 3, 3, 7'h40, 0, 0, "LCC");
    run_case(3, 3, 1, 7'h45, 0, 0, "CCH");
    run_case(0, 0, 0, 7'h00, 1, 0, "LLL undefined");
    running = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule